// File: doc/BRIEF.md
# Anode Wire Track Pattern Trigger

This block forms trigger primitives from the anode wire groups of a six-layer wire chamber. On every bunch crossing it takes one hit bit per wire group per layer. Each channel can be held back by a whole number of crossings and then widened over a few crossings, so that hits from the same track that arrive late still line up. For every key wire group it counts how many layers have a hit inside a track-shaped envelope. The envelope is one group wide at the key layer and becomes wider towards the outer layers.

Two thresholds act on that layer count. A low threshold raises an early pre-trigger flag. A key becomes a candidate only when its count also reaches the higher confirmation threshold. On every crossing the block reports up to two segments: the strongest candidate, and the strongest remaining candidate that does not sit next to the first. Each segment carries its key wire group, layer count, a 2-bit quality and the bunch-crossing number. The thresholds, the per-channel delays and the widening length are inputs that a control register bank outside the block holds steady.

Top module: `atrig_top`

## Requirements
- R1: After a synchronous reset the outputs `pretrig`, `seg0_vld` and `seg1_vld` are low, and both bunch-crossing fields read 0.
- R2: Layers are numbered 0 to 5, and layer 2 is the key layer. Layer L of key k looks at wire groups k+lo..k+hi, where (lo,hi) is (-2,0) for layer 0, (-1,0) for layer 1, (0,0) for layer 2, (0,1) for layer 3, and (0,2) for layers 4 and 5. Groups outside 0..NWG-1 count as empty. A key's count is the number of layers that have at least one hit in their span.
- R3: `pretrig` is high when some key has a nonzero count that is at least `pre_thr`. It is aligned with the segment outputs of the same crossing.
- R4: A key is a candidate only when its count is nonzero, at least `pre_thr` and at least `conf_thr`. Counts below either threshold give no segment.
- R5: Segment 0 is the candidate with the largest count. On equal counts the lowest key index wins.
- R6: Segment 1 is chosen by the rule of R5 among the candidates whose key differs from segment 0's key by at least 2. `seg1_vld` is never high without `seg0_vld`.
- R7: Quality is the count minus 3, or 0 when the count is 3 or less.
- R8: A 12-bit crossing counter starts at 0 on the first clock after reset and advances by one on every clock. A segment's bx field holds the counter value of the crossing just before the one in which the segment appears.
- R9: Channel `layer*NWG + wg` is delayed by the 2-bit value at `dly_cfg[ch*2 +: 2]`, which adds 0 to 3 whole crossings.
- R10: After its delay, each channel hit stays active for `str_len` crossings. A value of 0 acts as 1, and values above MAX_STR act as MAX_STR.
- R11: With zero delay, hits present at clock edge E appear in the segment and `pretrig` outputs after edge E+2.

Ports are listed at their default sizes (NWG = 112, DLY_W = 2, MAX_STR = 4, BX_W = 12).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| rst | input | 1 | Synchronous reset, active high |
| hits | input | 672 | Hit bits, index layer*NWG + wire group |
| dly_cfg | input | 1344 | Per-channel delay in crossings, 2 bits per channel |
| str_len | input | 3 | Hit widening length in crossings |
| pre_thr | input | 3 | Pre-trigger layer threshold |
| conf_thr | input | 3 | Confirmation layer threshold |
| pretrig | output | 1 | Some key reached the pre-trigger threshold |
| seg0_vld | output | 1 | Best segment present |
| seg0_key | output | 7 | Best segment key wire group |
| seg0_cnt | output | 3 | Best segment layer count |
| seg0_qual | output | 2 | Best segment quality |
| seg0_bx | output | 12 | Best segment crossing number |
| seg1_vld | output | 1 | Second segment present |
| seg1_key | output | 7 | Second segment key wire group |
| seg1_cnt | output | 3 | Second segment layer count |
| seg1_qual | output | 2 | Second segment quality |
| seg1_bx | output | 12 | Second segment crossing number |

## Verification
The best-segment search and the second-segment search act on the same crossing and can collide. The bench provokes this with pairs of tracks fired together: one pair has unequal counts, one pair ties, one pair has keys only one group apart, and one pair has keys exactly two groups apart. A scoreboard holds the expected pair for each output crossing, worked out from the envelope and threshold rules. It judges which candidate takes slot 0, whether the neighbour is suppressed, and whether the tie goes to the lower key. Pre-trigger-only crossings and per-channel delay with widening are judged the same way, crossing by crossing.

// File: rtl/atrig_pkg.sv
package atrig_pkg;
  localparam int NLAYER  = 6;
  localparam int ENV_MAX = 2;
  localparam int CNT_W   = $clog2(NLAYER + 1);

  // lower edge of the envelope span for a layer, relative to the key
  function automatic int env_lo(input int layer);
    case (layer)
      0:       return -2;
      1:       return -1;
      default: return 0;
    endcase
  endfunction

  // upper edge of the envelope span for a layer, relative to the key
  function automatic int env_hi(input int layer);
    case (layer)
      0, 1, 2: return 0;
      3:       return 1;
      default: return 2;
    endcase
  endfunction

  function automatic logic [1:0] cnt_to_qual(input logic [CNT_W-1:0] c);
    return (c > CNT_W'(3)) ? 2'(c - CNT_W'(3)) : 2'd0;
  endfunction
endpackage

// File: rtl/atrig_shape.sv
module atrig_shape #(
  parameter int NCH     = 672,
  parameter int DLY_W   = 2,
  parameter int MAX_STR = 4,
  parameter int STR_W   = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NCH-1:0]       hits,
  input  logic [NCH*DLY_W-1:0] dly_cfg,
  input  logic [STR_W-1:0]     str_len,
  output logic [NCH-1:0]       shaped
);
  localparam int MAXD  = (1 << DLY_W) - 1;
  localparam int DEPTH = MAXD + MAX_STR;

  int eff_len;
  always_comb begin
    if (str_len == '0)                eff_len = 1;
    else if (int'(str_len) > MAX_STR) eff_len = MAX_STR;
    else                              eff_len = int'(str_len);
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [DEPTH-1:0] hist;
    logic             win_or;
    always_ff @(posedge clk) begin
      if (rst) hist <= '0;
      else     hist <= {hist[DEPTH-2:0], hits[ch]};
    end
    always_comb begin
      int d;
      d = int'(dly_cfg[ch*DLY_W +: DLY_W]);
      win_or = 1'b0;
      for (int k = 0; k < DEPTH; k++)
        if (k >= d && k < d + eff_len) win_or = win_or | hist[k];
    end
    assign shaped[ch] = win_or;
  end
endmodule

// File: rtl/atrig_count.sv
module atrig_count
  import atrig_pkg::*;
#(
  parameter int NWG = 112
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NLAYER*NWG-1:0] shaped,
  input  logic [CNT_W-1:0]      pre_thr,
  output logic [CNT_W-1:0]      cnt_q [NWG],
  output logic                  pre_q
);
  logic [CNT_W-1:0] cnt_d [NWG];
  logic [NWG-1:0]   over_pre;

  for (genvar key = 0; key < NWG; key++) begin : g_key
    logic [CNT_W-1:0] c_loc;
    always_comb begin
      c_loc = '0;
      for (int l = 0; l < NLAYER; l++) begin
        logic any;
        any = 1'b0;
        for (int off = -ENV_MAX; off <= ENV_MAX; off++) begin
          int  w;
          int  idx;
          logic ok;
          w   = key + off;
          ok  = (off >= env_lo(l)) && (off <= env_hi(l)) && (w >= 0) && (w < NWG);
          idx = ok ? (l * NWG + w) : 0;
          any = any | (ok & shaped[idx]);
        end
        c_loc = c_loc + CNT_W'(any);
      end
    end
    assign cnt_d[key]    = c_loc;
    assign over_pre[key] = (c_loc != '0) && (c_loc >= pre_thr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NWG; k++) cnt_q[k] <= '0;
      pre_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      pre_q <= |over_pre;
    end
  end

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q[0] <= CNT_W'(NLAYER));
endmodule

// File: rtl/atrig_select.sv
module atrig_select
  import atrig_pkg::*;
#(
  parameter int NWG  = 112,
  parameter int KW   = 7,
  parameter int BX_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_q [NWG],
  input  logic             pre_q,
  input  logic [CNT_W-1:0] pre_thr,
  input  logic [CNT_W-1:0] conf_thr,
  output logic             pretrig,
  output logic             seg0_vld,
  output logic [KW-1:0]    seg0_key,
  output logic [CNT_W-1:0] seg0_cnt,
  output logic [1:0]       seg0_qual,
  output logic [BX_W-1:0]  seg0_bx,
  output logic             seg1_vld,
  output logic [KW-1:0]    seg1_key,
  output logic [CNT_W-1:0] seg1_cnt,
  output logic [1:0]       seg1_qual,
  output logic [BX_W-1:0]  seg1_bx
);
  logic [BX_W-1:0]  bx_ctr;
  logic             b_ok, s_ok;
  logic [KW-1:0]    b_k, s_k;
  logic [CNT_W-1:0] b_c, s_c;

  always_comb begin
    b_ok = 1'b0; b_k = '0; b_c = '0;
    for (int k = 0; k < NWG; k++) begin
      if (cnt_q[k] != '0 && cnt_q[k] >= pre_thr && cnt_q[k] >= conf_thr && cnt_q[k] > b_c) begin
        b_ok = 1'b1; b_k = KW'(k); b_c = cnt_q[k];
      end
    end
    s_ok = 1'b0; s_k = '0; s_c = '0;
    for (int k = 0; k < NWG; k++) begin
      int dk;
      dk = k - int'(b_k);
      if (dk < 0) dk = -dk;
      if (b_ok && dk >= 2 && cnt_q[k] != '0 && cnt_q[k] >= pre_thr &&
          cnt_q[k] >= conf_thr && cnt_q[k] > s_c) begin
        s_ok = 1'b1; s_k = KW'(k); s_c = cnt_q[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bx_ctr  <= '0;
      pretrig <= 1'b0;
      seg0_vld <= 1'b0; seg0_key <= '0; seg0_cnt <= '0; seg0_qual <= '0; seg0_bx <= '0;
      seg1_vld <= 1'b0; seg1_key <= '0; seg1_cnt <= '0; seg1_qual <= '0; seg1_bx <= '0;
    end else begin
      bx_ctr   <= bx_ctr + 1'b1;
      pretrig  <= pre_q;
      seg0_vld <= b_ok; seg0_key <= b_k; seg0_cnt <= b_c;
      seg0_qual <= cnt_to_qual(b_c); seg0_bx <= bx_ctr;
      seg1_vld <= s_ok; seg1_key <= s_k; seg1_cnt <= s_c;
      seg1_qual <= cnt_to_qual(s_c); seg1_bx <= bx_ctr;
    end
  end

  // R6
  seg_pair_chk: assert property (@(posedge clk) disable iff (rst)
    seg1_vld |-> seg0_vld);
  // R6
  seg_gap_chk: assert property (@(posedge clk) disable iff (rst)
    seg1_vld |-> ((seg0_key > seg1_key) ? (seg0_key - seg1_key) : (seg1_key - seg0_key)) >= KW'(2));
  // R5
  seg_rank_chk: assert property (@(posedge clk) disable iff (rst)
    seg1_vld |-> seg0_cnt >= seg1_cnt);
  // R4
  seg_conf_chk: assert property (@(posedge clk) disable iff (rst)
    seg0_vld |=> !seg0_vld || seg0_cnt >= $past(conf_thr));
endmodule

// File: rtl/atrig_top.sv
module atrig_top
  import atrig_pkg::*;
#(
  parameter int NWG     = 112,
  parameter int DLY_W   = 2,
  parameter int MAX_STR = 4,
  parameter int BX_W    = 12,
  localparam int NCH    = NLAYER * NWG,
  localparam int KW     = $clog2(NWG),
  localparam int STR_W  = $clog2(MAX_STR + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NCH-1:0]       hits,
  input  logic [NCH*DLY_W-1:0] dly_cfg,
  input  logic [STR_W-1:0]     str_len,
  input  logic [CNT_W-1:0]     pre_thr,
  input  logic [CNT_W-1:0]     conf_thr,
  output logic                 pretrig,
  output logic                 seg0_vld,
  output logic [KW-1:0]        seg0_key,
  output logic [CNT_W-1:0]     seg0_cnt,
  output logic [1:0]           seg0_qual,
  output logic [BX_W-1:0]      seg0_bx,
  output logic                 seg1_vld,
  output logic [KW-1:0]        seg1_key,
  output logic [CNT_W-1:0]     seg1_cnt,
  output logic [1:0]           seg1_qual,
  output logic [BX_W-1:0]      seg1_bx
);
  logic [NCH-1:0]   shaped;
  logic [CNT_W-1:0] cnt_q [NWG];
  logic             pre_q;

  atrig_shape #(.NCH(NCH), .DLY_W(DLY_W), .MAX_STR(MAX_STR), .STR_W(STR_W)) u_shape (
    .clk(clk), .rst(rst), .hits(hits), .dly_cfg(dly_cfg), .str_len(str_len), .shaped(shaped));

  atrig_count #(.NWG(NWG)) u_count (
    .clk(clk), .rst(rst), .shaped(shaped), .pre_thr(pre_thr), .cnt_q(cnt_q), .pre_q(pre_q));

  atrig_select #(.NWG(NWG), .KW(KW), .BX_W(BX_W)) u_sel (
    .clk(clk), .rst(rst), .cnt_q(cnt_q), .pre_q(pre_q), .pre_thr(pre_thr), .conf_thr(conf_thr),
    .pretrig(pretrig),
    .seg0_vld(seg0_vld), .seg0_key(seg0_key), .seg0_cnt(seg0_cnt), .seg0_qual(seg0_qual), .seg0_bx(seg0_bx),
    .seg1_vld(seg1_vld), .seg1_key(seg1_key), .seg1_cnt(seg1_cnt), .seg1_qual(seg1_qual), .seg1_bx(seg1_bx));
endmodule

// File: tb/tb_atrig_top.sv
module tb_atrig_top;
  localparam int NWG = 112;
  localparam int NCH = 6 * NWG;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NCH-1:0]   hits = '0;
  logic [NCH*2-1:0] dly_cfg = '0;
  logic [2:0] str_len = 3'd1, pre_thr = 3'd2, conf_thr = 3'd4;
  logic pretrig, seg0_vld, seg1_vld;
  logic [6:0] seg0_key, seg1_key;
  logic [2:0] seg0_cnt, seg1_cnt;
  logic [1:0] seg0_qual, seg1_qual;
  logic [11:0] seg0_bx, seg1_bx;

  always #4 clk = ~clk;

  atrig_top dut (.clk(clk), .rst(rst), .hits(hits), .dly_cfg(dly_cfg), .str_len(str_len),
    .pre_thr(pre_thr), .conf_thr(conf_thr), .pretrig(pretrig),
    .seg0_vld(seg0_vld), .seg0_key(seg0_key), .seg0_cnt(seg0_cnt), .seg0_qual(seg0_qual), .seg0_bx(seg0_bx),
    .seg1_vld(seg1_vld), .seg1_key(seg1_key), .seg1_cnt(seg1_cnt), .seg1_qual(seg1_qual), .seg1_bx(seg1_bx));

  typedef struct {
    int due; string tag; bit pre;
    bit v0; int k0; int c0;
    bit v1; int k1; int c1;
  } exp_t;
  exp_t sb[$];

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  always @(posedge clk) if (!rst) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int qual_of(input int c);
    return (c > 3) ? c - 3 : 0;
  endfunction

  // monitor: pops due items and compares
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due == cyc) begin
      exp_t e;
      e = sb.pop_front();
      check(pretrig == e.pre, e.tag, "pretrig", int'(pretrig), int'(e.pre));
      check(seg0_vld == e.v0, e.tag, "seg0_vld", int'(seg0_vld), int'(e.v0));
      check(seg1_vld == e.v1, e.tag, "seg1_vld", int'(seg1_vld), int'(e.v1));
      if (e.v0) begin
        check(int'(seg0_key) == e.k0, e.tag, "seg0_key", int'(seg0_key), e.k0);
        check(int'(seg0_cnt) == e.c0, e.tag, "seg0_cnt", int'(seg0_cnt), e.c0);
        check(int'(seg0_qual) == qual_of(e.c0), {e.tag, "/R7"}, "seg0_qual", int'(seg0_qual), qual_of(e.c0));
        check(int'(seg0_bx) == (e.due - 1) % 4096, {e.tag, "/R8"}, "seg0_bx", int'(seg0_bx), (e.due - 1) % 4096);
      end
      if (e.v1) begin
        check(int'(seg1_key) == e.k1, e.tag, "seg1_key", int'(seg1_key), e.k1);
        check(int'(seg1_cnt) == e.c1, e.tag, "seg1_cnt", int'(seg1_cnt), e.c1);
        check(int'(seg1_qual) == qual_of(e.c1), {e.tag, "/R7"}, "seg1_qual", int'(seg1_qual), qual_of(e.c1));
        check(int'(seg1_bx) == (e.due - 1) % 4096, {e.tag, "/R8"}, "seg1_bx", int'(seg1_bx), (e.due - 1) % 4096);
      end
    end
  end

  task automatic put(input int l, input int w);
    hits[l * NWG + w] = 1'b1;
  endtask

  task automatic push(input int due, input string tag, input bit pre,
                      input bit v0, input int k0, input int c0,
                      input bit v1, input int k1, input int c1);
    exp_t e;
    e.due = due; e.tag = tag; e.pre = pre;
    e.v0 = v0; e.k0 = k0; e.c0 = c0; e.v1 = v1; e.k1 = k1; e.c1 = c1;
    sb.push_back(e);
  endtask

  // drive one crossing of hits (already staged via put), then drain
  task automatic fire_and_drain();
    @(negedge clk);
    hits = '0;
    repeat (9) @(negedge clk);
  endtask

  initial begin
    int c;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R1: reset state
    check(!pretrig, "R1", "pretrig", int'(pretrig), 0);
    check(!seg0_vld && !seg1_vld, "R1", "vld", int'(seg0_vld) + int'(seg1_vld), 0);
    check(seg0_bx == 0 && seg1_bx == 0, "R1", "bx", int'(seg0_bx) + int'(seg1_bx), 0);
    repeat (2) @(negedge clk);

    // R2 R5 R11: straight six-layer track at wire group 50
    c = cyc;
    for (int l = 0; l < 6; l++) put(l, 50);
    push(c + 2, "R11", 0, 0, 0, 0, 0, 0, 0);
    push(c + 3, "R2", 1, 1, 50, 6, 0, 0, 0);
    fire_and_drain();

    // R3 R4: three layers, pre-trigger without confirmation
    c = cyc;
    for (int l = 0; l < 3; l++) put(l, 20);
    push(c + 3, "R4", 1, 0, 0, 0, 0, 0, 0);
    fire_and_drain();

    // R3: single hit below pre-trigger level is ignored
    c = cyc;
    put(2, 30);
    push(c + 3, "R3", 0, 0, 0, 0, 0, 0, 0);
    fire_and_drain();

    // R5 R6: two tracks of unequal strength
    c = cyc;
    for (int l = 0; l < 5; l++) put(l, 10);
    for (int l = 0; l < 6; l++) put(l, 80);
    push(c + 3, "R6", 1, 1, 80, 6, 1, 10, 5);
    fire_and_drain();

    // R5: tie goes to the lower key
    c = cyc;
    for (int l = 0; l < 4; l++) begin put(l, 30); put(l, 90); end
    push(c + 3, "R5", 1, 1, 30, 4, 1, 90, 4);
    fire_and_drain();

    // R6: neighbour one group away is suppressed
    c = cyc;
    for (int l = 0; l < 6; l++) put(l, 60);
    put(2, 61); put(3, 61);
    push(c + 3, "R6", 1, 1, 60, 6, 0, 0, 0);
    fire_and_drain();

    // R6: candidate exactly two groups away is kept
    c = cyc;
    for (int l = 0; l < 6; l++) put(l, 40);
    put(1, 42); put(2, 42); put(3, 42);
    push(c + 3, "R6", 1, 1, 40, 6, 1, 42, 4);
    fire_and_drain();

    // R4: lower confirmation threshold lets three layers through
    conf_thr = 3'd3;
    c = cyc;
    for (int l = 0; l < 3; l++) put(l, 20);
    push(c + 3, "R4", 1, 1, 20, 3, 0, 0, 0);
    fire_and_drain();

    // R4: pre-trigger threshold above the count blocks the segment
    pre_thr = 3'd4;
    c = cyc;
    for (int l = 0; l < 3; l++) put(l, 20);
    push(c + 3, "R4", 0, 0, 0, 0, 0, 0, 0);
    fire_and_drain();
    pre_thr = 3'd2; conf_thr = 3'd4;

    // R9: layer 0 channel of wire group 50 delayed by one crossing
    dly_cfg[50 * 2 +: 2] = 2'd1;
    c = cyc;
    for (int l = 0; l < 6; l++) put(l, 50);
    push(c + 3, "R9", 1, 1, 50, 5, 0, 0, 0);
    push(c + 4, "R9", 0, 0, 0, 0, 0, 0, 0);
    fire_and_drain();

    // R10: widening over two crossings realigns the late hit
    str_len = 3'd2;
    c = cyc;
    for (int l = 0; l < 6; l++) put(l, 50);
    push(c + 3, "R10", 1, 1, 50, 5, 0, 0, 0);
    push(c + 4, "R10", 1, 1, 50, 6, 0, 0, 0);
    push(c + 5, "R10", 0, 0, 0, 0, 0, 0, 0);
    fire_and_drain();

    // R10: length 0 acts as 1
    str_len = 3'd0;
    dly_cfg = '0;
    c = cyc;
    for (int l = 0; l < 6; l++) put(l, 50);
    push(c + 3, "R10", 1, 1, 50, 6, 0, 0, 0);
    push(c + 4, "R10", 0, 0, 0, 0, 0, 0, 0);
    fire_and_drain();

    check(sb.size() == 0, "R11", "scoreboard left", sb.size(), 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R11 watchdog: actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule